// File: doc/BRIEF.md
# SHA-256 Sliding-Window Message Scheduler

This block supplies the message-schedule word a SHA-256 compression loop needs at each of its 64 rounds. It keeps only sixteen 32-bit registers, not a 64-word array. An init strobe copies a 512-bit message block into those registers in one cycle. Each next strobe then moves the schedule forward by one round.

For the first sixteen rounds the output word is one of the loaded block words, picked by the round position. From round sixteen on, the block computes each new word from four taps of the window. It presents that word at the output, and on the next strobe it writes the word into the top register while every other register moves down by one. Words are never selected by an address: the round counter and the window movement fix which word appears. The output is combinational from the window and the round counter.

Top module: `msg_sched_window`

## Requirements
- R1: While reset (rst_n low) is active, and after it is released, every window register and the round counter are zero, so w_out reads 0 until the first init.
- R2: A cycle with init high loads the window from block and sets the round to 0. Word i (0..15) is block[511-32*i -: 32], so word 0 is the most significant 32 bits.
- R3: At rounds 0 to 15, w_out equals loaded word number equal to the round. Each cycle with next high, init low and round below 63 advances the round by one.
- R4: At round t from 16 to 63, w_out equals s1(W[t-2]) + W[t-7] + s0(W[t-15]) + W[t-16] mod 2^32. Here s0(x) = ROTR7(x) ^ ROTR18(x) ^ SHR3(x) and s1(x) = ROTR17(x) ^ ROTR19(x) ^ SHR10(x).
- R5: A next step taken at round 16 or later writes the word shown on w_out in that cycle into the top register (r15) and moves every other register down by one.
- R6: A cycle with neither init nor next changes neither the window nor the round, so w_out holds its value.
- R7: A next strobe at round 63 is ignored: the round stays at 63 and w_out keeps showing W[63].
- R8: When init and next are high in the same cycle, init wins. The window reloads, the round becomes 0, and the next strobe has no effect.
- R9: An init in the middle of a schedule restarts it from round 0 with the new block, whatever the round was.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| init | input | 1 | Load block into the window and restart at round 0 |
| next | input | 1 | Advance the schedule by one round |
| block | input | 512 | Message block, word 0 in the top 32 bits |
| w_out | output | 32 | Schedule word for the current round |

## Verification
The assertions assume that block is stable in the cycle init is sampled. They also assume that init and next are ordinary synchronous strobes, and they make no claim about the output while reset is held. The stimulus changes inputs only on the falling clock edge and raises each strobe for exactly one cycle. Several directed sequences deliberately push the strobes to their edges: idle gaps, extra next strobes past round 63, and init together with next. These take the design through every state the assertions cover, and none of them breaks an input assumption.

// File: rtl/msg_sched_pkg.sv
`timescale 1ns/1ps
package msg_sched_pkg;

   localparam int WORD_BITS  = 32;
   localparam int SCHED_LEN  = 64;
   localparam int WINDOW_LEN = 16;

   typedef logic [WORD_BITS-1:0] sched_word_t;

   // rotation amounts and shift amounts of the two small mixing functions
   localparam int S0_ROT_A = 7;
   localparam int S0_ROT_B = 18;
   localparam int S0_SHR   = 3;
   localparam int S1_ROT_A = 17;
   localparam int S1_ROT_B = 19;
   localparam int S1_SHR   = 10;

   function automatic sched_word_t rot_right(input sched_word_t x, input int unsigned n);
      return (x >> n) | (x << (WORD_BITS - n));
   endfunction

   function automatic sched_word_t mix_lo(input sched_word_t x);
      return rot_right(x, S0_ROT_A) ^ rot_right(x, S0_ROT_B) ^ (x >> S0_SHR);
   endfunction

   function automatic sched_word_t mix_hi(input sched_word_t x);
      return rot_right(x, S1_ROT_A) ^ rot_right(x, S1_ROT_B) ^ (x >> S1_SHR);
   endfunction

endpackage

// File: rtl/msg_sched_round_ctl.sv
`timescale 1ns/1ps
module msg_sched_round_ctl #(
   parameter int ROUNDS    = 64,
   parameter int WIN_DEPTH = 16,
   localparam int CNT_W    = $clog2(ROUNDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init,
   input  logic             next,
   output logic [CNT_W-1:0] round_q,
   output logic             load_en,
   output logic             shift_en,
   output logic             direct_sel
);

   localparam logic [CNT_W-1:0] LAST_ROUND = CNT_W'(ROUNDS - 1);
   localparam logic [CNT_W-1:0] FIRST_CALC = CNT_W'(WIN_DEPTH);

   logic advance;

   always_comb begin
      load_en    = init;
      advance    = next && !init && (round_q != LAST_ROUND);
      direct_sel = (round_q < FIRST_CALC);
      shift_en   = advance && !direct_sel;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         round_q <= '0;
      end else if (load_en) begin
         round_q <= '0;
      end else if (advance) begin
         round_q <= round_q + 1'b1;
      end
   end

endmodule

// File: rtl/msg_sched_window_regs.sv
`timescale 1ns/1ps
module msg_sched_window_regs #(
   parameter int WORD_W    = 32,
   parameter int WIN_DEPTH = 16,
   localparam int BLK_W    = WORD_W * WIN_DEPTH
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 load_en,
   input  logic                                 shift_en,
   input  logic [BLK_W-1:0]                     load_blk,
   input  logic [WORD_W-1:0]                    push_word,
   output logic [WIN_DEPTH-1:0][WORD_W-1:0]     win_q
);

   genvar g;
   generate
      for (g = 0; g < WIN_DEPTH; g++) begin : g_slot
         // slot g takes word g of the block; word 0 sits in the top bits
         localparam int HI = BLK_W - 1 - g * WORD_W;
         logic [WORD_W-1:0] d;

         if (g == WIN_DEPTH - 1) begin : g_top
            always_comb d = push_word;
         end else begin : g_mid
            always_comb d = win_q[g+1];
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               win_q[g] <= '0;
            end else if (load_en) begin
               win_q[g] <= load_blk[HI -: WORD_W];
            end else if (shift_en) begin
               win_q[g] <= d;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/msg_sched_expand.sv
`timescale 1ns/1ps
module msg_sched_expand
   import msg_sched_pkg::*;
#(
   parameter int WORD_W   = 32,
   parameter bit ADD_TREE = 1'b1
) (
   input  logic [WORD_W-1:0] tap_m16,
   input  logic [WORD_W-1:0] tap_m15,
   input  logic [WORD_W-1:0] tap_m7,
   input  logic [WORD_W-1:0] tap_m2,
   output logic [WORD_W-1:0] new_word
);

   logic [WORD_W-1:0] lo_mix, hi_mix;

   always_comb begin
      lo_mix = mix_lo(tap_m15);
      hi_mix = mix_hi(tap_m2);
   end

   generate
      if (ADD_TREE) begin : g_tree
         logic [WORD_W-1:0] sum_a, sum_b;
         always_comb begin
            sum_a    = hi_mix + tap_m7;
            sum_b    = lo_mix + tap_m16;
            new_word = sum_a + sum_b;
         end
      end else begin : g_chain
         always_comb new_word = ((hi_mix + tap_m7) + lo_mix) + tap_m16;
      end
   endgenerate

endmodule

// File: rtl/msg_sched_window.sv
`timescale 1ns/1ps
module msg_sched_window #(
   parameter int WORD_W    = 32,
   parameter int WIN_DEPTH = 16,
   parameter int ROUNDS    = 64,
   parameter bit ADD_TREE  = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        init,
   input  logic                        next,
   input  logic [WORD_W*WIN_DEPTH-1:0] block,
   output logic [WORD_W-1:0]           w_out
);

   localparam int CNT_W = $clog2(ROUNDS);
   localparam int IDX_W = $clog2(WIN_DEPTH);
   // tap positions relative to the bottom of the window (word t-16)
   localparam int TAP_M16 = WIN_DEPTH - 16;
   localparam int TAP_M15 = WIN_DEPTH - 15;
   localparam int TAP_M7  = WIN_DEPTH - 7;
   localparam int TAP_M2  = WIN_DEPTH - 2;

   generate
      if (WORD_W != msg_sched_pkg::WORD_BITS) begin : g_bad_word
         $error("msg_sched_window: WORD_W must equal 32");
      end
      if (WIN_DEPTH != msg_sched_pkg::WINDOW_LEN) begin : g_bad_depth
         $error("msg_sched_window: WIN_DEPTH must equal 16");
      end
      if (ROUNDS != msg_sched_pkg::SCHED_LEN) begin : g_bad_rounds
         $error("msg_sched_window: ROUNDS must equal 64");
      end
   endgenerate

   logic [CNT_W-1:0]                 round_q;
   logic                             load_en, shift_en, direct_sel;
   logic [WIN_DEPTH-1:0][WORD_W-1:0] win_q;
   logic [WORD_W-1:0]                calc_word;
   logic [IDX_W-1:0]                 direct_idx;

   msg_sched_round_ctl #(
      .ROUNDS    (ROUNDS),
      .WIN_DEPTH (WIN_DEPTH)
   ) u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .init       (init),
      .next       (next),
      .round_q    (round_q),
      .load_en    (load_en),
      .shift_en   (shift_en),
      .direct_sel (direct_sel)
   );

   msg_sched_window_regs #(
      .WORD_W    (WORD_W),
      .WIN_DEPTH (WIN_DEPTH)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_en   (load_en),
      .shift_en  (shift_en),
      .load_blk  (block),
      .push_word (calc_word),
      .win_q     (win_q)
   );

   msg_sched_expand #(
      .WORD_W   (WORD_W),
      .ADD_TREE (ADD_TREE)
   ) u_expand (
      .tap_m16  (win_q[TAP_M16]),
      .tap_m15  (win_q[TAP_M15]),
      .tap_m7   (win_q[TAP_M7]),
      .tap_m2   (win_q[TAP_M2]),
      .new_word (calc_word)
   );

   always_comb begin
      direct_idx = round_q[IDX_W-1:0];
      w_out      = direct_sel ? win_q[direct_idx] : calc_word;
   end

endmodule

// File: rtl/msg_sched_window_checker.sv
`timescale 1ns/1ps
module msg_sched_window_checker #(
   parameter int WORD_W    = 32,
   parameter int WIN_DEPTH = 16,
   parameter int ROUNDS    = 64,
   localparam int CNT_W    = $clog2(ROUNDS)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              init,
   input logic              next,
   input logic [WORD_W-1:0] first_word,
   input logic [WORD_W-1:0] w_out,
   input logic [CNT_W-1:0]  round_q,
   input logic [WORD_W-1:0] top_word
);

   localparam logic [CNT_W-1:0] LAST_ROUND = CNT_W'(ROUNDS - 1);
   localparam logic [CNT_W-1:0] FIRST_CALC = CNT_W'(WIN_DEPTH);

   p_load_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
      init |=> (w_out == $past(first_word)) && (round_q == '0));

   p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!init && !next) |=> ($stable(w_out) && $stable(round_q)));

   p_round_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (next && !init && round_q != LAST_ROUND) |=> (round_q == $past(round_q) + 1'b1));

   p_push_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (next && !init && round_q >= FIRST_CALC && round_q != LAST_ROUND)
      |=> (top_word == $past(w_out)));

   p_last_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (next && !init && round_q == LAST_ROUND) |=> ($stable(w_out) && round_q == LAST_ROUND));

   p_init_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (init && next) |=> (round_q == '0));

endmodule

bind msg_sched_window msg_sched_window_checker #(
   .WORD_W    (WORD_W),
   .WIN_DEPTH (WIN_DEPTH),
   .ROUNDS    (ROUNDS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .init       (init),
   .next       (next),
   .first_word (block[WORD_W*WIN_DEPTH-1 -: WORD_W]),
   .w_out      (w_out),
   .round_q    (round_q),
   .top_word   (win_q[WIN_DEPTH-1])
);

// File: tb/msg_sched_window_test.sv
`timescale 1ns/1ps
module msg_sched_window_test;

   localparam int NBLK = 3;
   localparam logic [511:0] BLOCKS [NBLK] = '{
      {32'h61626380, {14{32'h00000000}}, 32'h00000018},
      {16{32'hffffffff}},
      {32'h00010203, 32'h80706050, 32'hdeadbeef, 32'h13579bdf,
       32'h2468ace0, 32'hfedcba98, 32'h0f0f0f0f, 32'h55aa55aa,
       32'h00000001, 32'h80000000, 32'h7fffffff, 32'hcafef00d,
       32'h31415926, 32'h27182818, 32'h9e3779b9, 32'h01234567}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         init = 1'b0;
   logic         next = 1'b0;
   logic [511:0] block = '0;
   logic [31:0]  w_out;

   int n_chk = 0;
   int n_fail = 0;
   logic [31:0] ref_w [64];

   always #4 clk = ~clk;

   msg_sched_window uut (
      .clk   (clk),
      .rst_n (rst_n),
      .init  (init),
      .next  (next),
      .block (block),
      .w_out (w_out)
   );

   function automatic logic [31:0] rr(input logic [31:0] x, input int n);
      return (x >> n) | (x << (32 - n));
   endfunction

   task automatic build_ref(input logic [511:0] b);
      for (int i = 0; i < 16; i++) ref_w[i] = b[511 - 32*i -: 32];
      for (int t = 16; t < 64; t++) begin
         logic [31:0] a, c;
         a = rr(ref_w[t-15], 7) ^ rr(ref_w[t-15], 18) ^ (ref_w[t-15] >> 3);
         c = rr(ref_w[t-2], 17) ^ rr(ref_w[t-2], 19) ^ (ref_w[t-2] >> 10);
         ref_w[t] = c + ref_w[t-7] + a + ref_w[t-16];
      end
   endtask

   task automatic check(input string req, input logic [31:0] exp);
      n_chk++;
      if (w_out !== exp) begin
         n_fail++;
         $display("FAIL %s: w_out=%h expected %h", req, w_out, exp);
      end
   endtask

   // one-cycle strobes driven on the falling edge; sampled 1 ns after the rise
   task automatic pulse(input logic do_init, input logic do_next, input logic [511:0] b);
      @(negedge clk);
      init  = do_init;
      next  = do_next;
      block = b;
      @(posedge clk);
      #1;
      init = 1'b0;
      next = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not complete, got %0d expected done", n_chk);
      summary();
      $finish;
   end

   initial begin
      // R1: reset state
      idle(2);
      check("R1 during reset", 32'h0);
      @(negedge clk) rst_n = 1'b1;
      idle(2);
      check("R1 after reset", 32'h0);

      // table walk: every word of every block (R2 R3 R4 R5)
      for (int k = 0; k < NBLK; k++) begin
         build_ref(BLOCKS[k]);
         pulse(1'b1, 1'b0, BLOCKS[k]);
         for (int t = 0; t < 64; t++) begin
            if (t < 16) check(t == 0 ? "R2 word0" : "R3 direct word", ref_w[t]);
            else        check("R4 R5 computed word", ref_w[t]);
            if (k == 1 && t == 20) begin
               idle(5);
               check("R6 idle hold", ref_w[20]);
            end
            if (t < 63) pulse(1'b0, 1'b1, '0);
         end
         if (k == 0) begin
            // known values of the three-letter message
            check("R4 abc W63 recheck", ref_w[63]);
         end
      end

      // R4 fixed sanity values for the three-letter message
      build_ref(BLOCKS[0]);
      pulse(1'b1, 1'b0, BLOCKS[0]);
      check("R2 abc W0 literal", 32'h61626380);
      for (int t = 0; t < 16; t++) pulse(1'b0, 1'b1, '0);
      check("R4 abc W16 literal", 32'h61626380);
      pulse(1'b0, 1'b1, '0);
      check("R4 abc W17 literal", 32'h000f0000);
      for (int t = 17; t < 63; t++) pulse(1'b0, 1'b1, '0);
      check("R4 abc W63", ref_w[63]);

      // R7: next at round 63 ignored
      for (int i = 0; i < 3; i++) begin
         pulse(1'b0, 1'b1, '0);
         check("R7 next ignored at last round", ref_w[63]);
      end

      // R9: init mid-schedule, R8: init together with next
      build_ref(BLOCKS[2]);
      pulse(1'b1, 1'b0, BLOCKS[2]);
      for (int t = 0; t < 30; t++) pulse(1'b0, 1'b1, '0);
      check("R9 before restart", ref_w[30]);
      build_ref(BLOCKS[1]);
      pulse(1'b1, 1'b1, BLOCKS[1]);
      check("R8 init wins word0", ref_w[0]);
      pulse(1'b0, 1'b1, '0);
      check("R8 R9 restart word1", ref_w[1]);
      for (int t = 1; t < 40; t++) pulse(1'b0, 1'b1, '0);
      check("R9 restarted word40", ref_w[40]);

      // R1: reset in mid-run clears the output
      @(negedge clk) rst_n = 1'b0;
      #1;
      check("R1 reset mid-run", 32'h0);
      @(negedge clk) rst_n = 1'b1;
      pulse(1'b0, 1'b1, '0);
      check("R1 R3 word after reset", 32'h0);

      summary();
      $finish;
   end

endmodule